// File: doc/BRIEF.md
# Analog Input Scan List and Gain Configuration

This block holds the software-programmed setup of a multichannel analog input front end for one acquisition task. A byte-wide host port writes a channel pointer; every pointer write both selects the channel whose gain is being programmed and appends that channel to an ordered scan list of up to sixteen entries. A gain write then stores a two-bit range code for the channel the pointer currently names. A one-shot wipe command empties the scan list and returns every channel's gain to the default range.

The block also holds a five-bit trigger select. Its upper two bits choose a source group, and its lower three bits choose a channel within the main or extended group. A marker write produces a single-cycle pulse that flags the last conversion of the task. The scan list, the per-channel gains and the decoded trigger selection leave the block as parallel outputs for the multiplexer and timing logic.

The sequencing core is a four-state machine. EMPTY (list length 0) moves to FILL on a pointer write (APPEND_FIRST). FILL stays in FILL on each further pointer write (APPEND) and moves to FULL when the sixteenth entry is written (APPEND_LAST). FULL holds the list (HOLD). A wipe write in EMPTY, FILL or FULL moves to WIPE (WIPE_REQ). WIPE always returns to EMPTY after one cycle (WIPE_DONE), clearing the list and the gains on that edge.

Top module: `aicfg_regs`

## Requirements
- R1: After reset, the list length is 0, every scan list entry and every gain is 0, the pointer is 0, the trigger select is 0 and the marker pulse is low.
- R2: A write to address 0 loads bits [3:0] into the channel pointer, stores that channel in scan list entry number (current length) and raises the length by one on the same edge; bits [7:4] are ignored. Entry i of `scan_list` sits at bits [4i+3:4i].
- R3: With 16 entries in the list, a pointer write still updates the pointer but neither the list nor the length changes.
- R4: A write to address 1 stores bits [1:0] as the gain of the channel the pointer names and of no other channel (00 = 5 V, 01 = 10 V, 10 = 2 V, 11 = 1 V); reading address 1 returns that channel's gain in bits [1:0] with bits [7:2] zero. The gain of channel c sits at `chan_gain` bits [2c+1:2c].
- R5: A write to address 2 with bit 0 set makes address 2 read 1 during the following cycle; on the next edge every gain and scan list entry becomes 0, the length becomes 0 and address 2 reads 0 again. A write with bit 0 clear has no effect.
- R6: Pointer and gain writes that arrive during the wipe cycle are dropped.
- R7: A write to address 3 stores bits [4:0] as the trigger select, read back at address 3 with bits [7:5] zero; `trig_src` equals bits [4:3] (00 main, 01 extended, 10 auxiliary 0, 11 auxiliary 1).
- R8: `trig_chan` equals bits [2:0] for the main source, 8 plus bits [2:0] for the extended source, and 0 for either auxiliary source.
- R9: A write to address 4 with bit 0 set raises `acq_last` for exactly the one cycle after the write; reading address 4 returns `ext_present` in bit 1 and zero elsewhere.
- R10: Reading address 0 returns the pointer and reading address 5 returns the list length, both zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 3 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for `bus_addr` |
| ext_present | input | 1 | Extended channel bank fitted |
| scan_list | output | 64 | Ordered channel list, 4 bits per entry |
| scan_len | output | 5 | Number of valid scan list entries |
| chan_gain | output | 32 | Gain code per channel, 2 bits each |
| trig_src | output | 2 | Decoded trigger source group |
| trig_chan | output | 4 | Decoded trigger channel |
| acq_last | output | 1 | One-cycle last-conversion marker |

## Verification
A corrupted state register shows up at the ports within one cycle: a machine stuck in WIPE keeps address 2 reading 1 and drops the next pointer write, so the length fails to advance; a machine that reaches FULL early freezes `scan_len` below 16. A wrong length count misplaces the next appended channel in `scan_list`, visible on the edge of that write. A gain write steered to the wrong channel changes a neighbour's field in `chan_gain` on the write edge, and readback at address 1 exposes it as soon as the pointer selects either channel.

// File: rtl/aicfg_pkg.sv
package aicfg_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_FILL  = 2'd1,
        S_FULL  = 2'd2,
        S_WIPE  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        TS_MAIN = 2'd0,
        TS_EXT  = 2'd1,
        TS_AUX0 = 2'd2,
        TS_AUX1 = 2'd3
    } trig_src_e;

    localparam int ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] A_PTR  = 3'd0;
    localparam logic [ADDR_W-1:0] A_GAIN = 3'd1;
    localparam logic [ADDR_W-1:0] A_WIPE = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIG = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACQ  = 3'd4;
    localparam logic [ADDR_W-1:0] A_LEN  = 3'd5;

    localparam int TRIG_W   = 5;
    localparam int TCHAN_W  = 4;
endpackage

// File: rtl/aicfg_seq_fsm.sv
module aicfg_seq_fsm
    import aicfg_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int CH_W  = $clog2(NCH),
    parameter int LEN_W = $clog2(NCH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ptr_we,
    input  logic [CH_W-1:0]       ptr_wdata,
    input  logic                  wipe_req,
    output logic [CH_W-1:0]       ptr_q,
    output logic [LEN_W-1:0]      len_q,
    output logic [NCH*CH_W-1:0]   list_q,
    output logic                  wiping
);
    localparam logic [LEN_W-1:0] LAST_IDX = LEN_W'(NCH - 1);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(NCH);

    seq_state_e state_q, state_d;
    logic       append;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (wipe_req) state_d = S_WIPE;
                     else if (ptr_we) state_d = (NCH == 1) ? S_FULL : S_FILL;
            S_FILL:  if (wipe_req) state_d = S_WIPE;
                     else if (ptr_we && len_q == LAST_IDX) state_d = S_FULL;
            S_FULL:  if (wipe_req) state_d = S_WIPE;
            S_WIPE:  state_d = S_EMPTY;
        endcase
    end

    // outputs of the machine
    always_comb begin
        append = 1'b0;
        wiping = 1'b0;
        unique case (state_q)
            S_EMPTY, S_FILL: append = ptr_we;
            S_FULL:          append = 1'b0;
            S_WIPE:          wiping = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_we && !wiping) begin
            ptr_q <= ptr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || wiping) len_q <= '0;
        else if (append)      len_q <= len_q + 1'b1;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n || wiping)
                list_q[i*CH_W +: CH_W] <= '0;
            else if (append && len_q == LEN_W'(i))
                list_q[i*CH_W +: CH_W] <= ptr_wdata;
        end
    end

    a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= FULL_LEN);
    a_r2_append_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && (state_q == S_EMPTY || state_q == S_FILL)) |=> (len_q == $past(len_q) + 1'b1));
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FULL && !wipe_req) |=> $stable(len_q) && $stable(list_q));
    a_r5_wipe_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WIPE) |=> (state_q == S_EMPTY && len_q == '0));
endmodule

// File: rtl/aicfg_gain_bank.sv
module aicfg_gain_bank #(
    parameter int NCH    = 16,
    parameter int CH_W   = $clog2(NCH),
    parameter int GAIN_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CH_W-1:0]       sel,
    input  logic [GAIN_W-1:0]     wdata,
    input  logic                  wipe,
    output logic [NCH*GAIN_W-1:0] gains,
    output logic [GAIN_W-1:0]     rd_gain
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                gains[c*GAIN_W +: GAIN_W] <= '0;
            else if (we && sel == CH_W'(c))
                gains[c*GAIN_W +: GAIN_W] <= wdata;
        end
    end

    assign rd_gain = gains[sel*GAIN_W +: GAIN_W];

    a_r5_gains_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (gains == '0));
    a_r4_gain_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wipe) |=> (gains[$past(sel)*GAIN_W +: GAIN_W] == $past(wdata)));
endmodule

// File: rtl/aicfg_trig_decode.sv
module aicfg_trig_decode
    import aicfg_pkg::*;
(
    input  logic [TRIG_W-1:0]  sel,
    output logic [1:0]         src,
    output logic [TCHAN_W-1:0] chan
);
    trig_src_e grp;
    assign grp = trig_src_e'(sel[4:3]);
    assign src = sel[4:3];

    always_comb begin
        unique case (grp)
            TS_MAIN:          chan = {1'b0, sel[2:0]};
            TS_EXT:           chan = {1'b1, sel[2:0]};
            TS_AUX0, TS_AUX1: chan = '0;
        endcase
    end
endmodule

// File: rtl/aicfg_regs.sv
module aicfg_regs
    import aicfg_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int GAIN_W = 2,
    parameter int DATA_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_wr,
    input  logic [2:0]                            bus_addr,
    input  logic [7:0]                            bus_wdata,
    output logic [7:0]                            bus_rdata,
    input  logic                                  ext_present,
    output logic [NCH*$clog2(NCH)-1:0]            scan_list,
    output logic [$clog2(NCH+1)-1:0]              scan_len,
    output logic [NCH*GAIN_W-1:0]                 chan_gain,
    output logic [1:0]                            trig_src,
    output logic [3:0]                            trig_chan,
    output logic                                  acq_last
);
    localparam int CH_W  = $clog2(NCH);
    localparam int LEN_W = $clog2(NCH + 1);

    logic              ptr_we, gain_we, wipe_req, trig_we, acq_we;
    logic              wiping;
    logic [CH_W-1:0]   ptr_q;
    logic [GAIN_W-1:0] rd_gain;
    logic [TRIG_W-1:0] trig_q;
    logic [DATA_W-1:0] wd;
    logic              unused_wd;

    assign wd        = bus_wdata[DATA_W-1:0];
    assign unused_wd = ^wd;

    assign ptr_we   = bus_wr && bus_addr == A_PTR;
    assign gain_we  = bus_wr && bus_addr == A_GAIN && !wiping;
    assign wipe_req = bus_wr && bus_addr == A_WIPE && wd[0];
    assign trig_we  = bus_wr && bus_addr == A_TRIG;
    assign acq_we   = bus_wr && bus_addr == A_ACQ && wd[0];

    aicfg_seq_fsm #(.NCH(NCH), .CH_W(CH_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_we    (ptr_we),
        .ptr_wdata (wd[CH_W-1:0]),
        .wipe_req  (wipe_req),
        .ptr_q     (ptr_q),
        .len_q     (scan_len),
        .list_q    (scan_list),
        .wiping    (wiping)
    );

    aicfg_gain_bank #(.NCH(NCH), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (gain_we),
        .sel     (ptr_q),
        .wdata   (wd[GAIN_W-1:0]),
        .wipe    (wiping),
        .gains   (chan_gain),
        .rd_gain (rd_gain)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q   <= '0;
            acq_last <= 1'b0;
        end else begin
            if (trig_we) trig_q <= wd[TRIG_W-1:0];
            acq_last <= acq_we;
        end
    end

    aicfg_trig_decode u_trig (
        .sel  (trig_q),
        .src  (trig_src),
        .chan (trig_chan)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_PTR:   bus_rdata[CH_W-1:0]   = ptr_q;
            A_GAIN:  bus_rdata[GAIN_W-1:0] = rd_gain;
            A_WIPE:  bus_rdata[0]          = wiping;
            A_TRIG:  bus_rdata[TRIG_W-1:0] = trig_q;
            A_ACQ:   bus_rdata[1]          = ext_present;
            A_LEN:   bus_rdata[LEN_W-1:0]  = scan_len;
            default: bus_rdata = '0;
        endcase
    end

    a_r9_marker_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        acq_we |=> acq_last);
    a_r9_marker_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_we |=> !acq_last);
    a_r8_aux_no_chan: assert property (@(posedge clk) disable iff (!rst_n)
        trig_src[1] |-> (trig_chan == '0));
    a_r6_drop_in_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        wiping |=> (scan_len == '0 && chan_gain == '0));
endmodule

// File: tb/aicfg_regs_test.sv
module aicfg_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_present = 1'b0;
    logic [63:0] scan_list;
    logic [4:0]  scan_len;
    logic [31:0] chan_gain;
    logic [1:0]  trig_src;
    logic [3:0]  trig_chan;
    logic        acq_last;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aicfg_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_present(ext_present),
        .scan_list(scan_list), .scan_len(scan_len), .chan_gain(chan_gain),
        .trig_src(trig_src), .trig_chan(trig_chan), .acq_last(acq_last)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [21:0] VEC [10] = '{
        {3'd0, 8'h13, 3'd5, 8'h01},   // R2 upper bits ignored, length 1
        {3'd1, 8'h02, 3'd1, 8'h02},   // R4 gain ch3 = 2 V
        {3'd0, 8'h05, 3'd0, 8'h05},   // R10 pointer readback
        {3'd1, 8'h03, 3'd1, 8'h03},   // R4 gain ch5 = 1 V
        {3'd0, 8'h03, 3'd1, 8'h02},   // R4 ch3 gain kept
        {3'd1, 8'hFD, 3'd1, 8'h01},   // R4 upper bits ignored
        {3'd3, 8'h0D, 3'd3, 8'h0D},   // R7 trigger readback
        {3'd3, 8'hF2, 3'd3, 8'h12},   // R7 upper bits ignored
        {3'd2, 8'h00, 3'd5, 8'h03},   // R5 wipe with bit0 clear ignored
        {3'd0, 8'h05, 3'd1, 8'h03}    // R2 ch5 appended, gain kept
    };

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, int exp);
        bus_addr = a;
        #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 len", int'(scan_len), 0);
        chk("R1 list", int'(scan_list != 0), 0);
        chk("R1 gains", int'(chan_gain), 0);
        chk("R1 trig_src", int'(trig_src), 0);
        chk("R1 acq_last", int'(acq_last), 0);
        rd_chk("R1 pointer", 3'd0, 0);

        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][21:19], VEC[i][18:11]);
            rd_chk($sformatf("vector %0d", i), VEC[i][10:8], int'(VEC[i][7:0]));
        end

        // R2 list order and R4 per-channel fields
        chk("R2 entry0", int'(scan_list[3:0]), 3);
        chk("R2 entry1", int'(scan_list[7:4]), 5);
        chk("R2 entry2", int'(scan_list[11:8]), 3);
        chk("R2 entry3", int'(scan_list[15:12]), 5);
        chk("R4 ch3 field", int'(chan_gain[7:6]), 1);
        chk("R4 ch5 field", int'(chan_gain[11:10]), 3);
        chk("R4 other fields", int'(chan_gain & ~32'h0000_0CC0), 0);

        // R7 R8 trigger decode
        chk("R8 aux0 src", int'(trig_src), 2);
        chk("R8 aux0 chan", int'(trig_chan), 0);
        wr(3'd3, 8'h0D);
        chk("R8 ext src", int'(trig_src), 1);
        chk("R8 ext chan", int'(trig_chan), 13);
        wr(3'd3, 8'h06);
        chk("R8 main src", int'(trig_src), 0);
        chk("R8 main chan", int'(trig_chan), 6);
        wr(3'd3, 8'h1F);
        chk("R8 aux1 src", int'(trig_src), 3);
        chk("R8 aux1 chan", int'(trig_chan), 0);

        // R9 marker pulse and presence bit
        ext_present = 1'b1;
        rd_chk("R9 presence", 3'd4, 2);
        wr(3'd4, 8'h01);
        chk("R9 pulse high", int'(acq_last), 1);
        @(negedge clk);
        chk("R9 pulse one cycle", int'(acq_last), 0);
        wr(3'd4, 8'h00);
        chk("R9 bit0 clear no pulse", int'(acq_last), 0);

        // R5 R6 wipe sequence with a pointer write in the wipe cycle
        wr(3'd2, 8'h01);
        rd_chk("R5 flag set", 3'd2, 1);
        chk("R5 len before wipe", int'(scan_len), 4);
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h07;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R5 flag cleared", 3'd2, 0);
        chk("R5 len zero", int'(scan_len), 0);
        chk("R5 gains zero", int'(chan_gain), 0);
        chk("R5 list zero", int'(scan_list != 0), 0);
        rd_chk("R6 pointer unchanged", 3'd0, 5);

        // R3 fill to 16 then overflow write
        for (int i = 0; i < 16; i++) wr(3'd0, 8'(i));
        chk("R3 len full", int'(scan_len), 16);
        rd_chk("R10 len read", 3'd5, 16);
        wr(3'd0, 8'h09);
        chk("R3 len held", int'(scan_len), 16);
        rd_chk("R3 pointer moves", 3'd0, 9);
        chk("R3 entry15", int'(scan_list[63:60]), 15);
        chk("R3 entry0", int'(scan_list[3:0]), 0);
        wr(3'd1, 8'h02);
        chk("R4 ch9 field", int'(chan_gain[19:18]), 2);
        chk("R4 ch9 only", int'(chan_gain & ~32'h000C_0000), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule